// File: doc/BRIEF.md
# Bit-Level Pipelined Ripple-Carry Adder

This block adds two unsigned operands and a carry-in. The carry chain is cut by a register after every bit position, so only one full adder stands between any two registers. The carry advances one bit per clock. The operand bits that have not yet been added move forward next to the partial result. The sum bits that are already resolved are carried along to the last level. There they appear together with the final carry.

An input level captures the operands and the carry-in. Each later level adds one bit. For the default width of 4 there are five register levels, holding 9, 8, 7, 6 and 5 bits. Each bit cell is a full adder built from two cascaded half adders. A valid flag runs in parallel with the data, so a new operation can enter on every clock and a finished result leaves on every clock. The block has no stall or back-pressure.

Top module: `rca_pipe_adder`

## Requirements
- R1: While rst_ni is low, valid_o is 0. After reset is released, valid_o stays 0 until the first operation accepted after the release has reached the output.
- R2: For every accepted operation, {carry_o, sum_o} equals x_i + y_i + carry_i as an unsigned sum of W+1 bits. carry_o is bit W and sum_o holds bits W-1..0.
- R3: An operation is accepted at a rising edge where rst_ni is high and in_valid_i is 1. Its result is presented, with valid_o high, after exactly W more rising edges, which is 4 for the default W. Counting the capture edge, that is W+1 register edges.
- R4: Operations accepted on consecutive clocks leave on consecutive clocks, one per clock with no gaps. Every accepted operation produces exactly one valid result.
- R5: A clock edge where in_valid_i is 0 produces a cycle with valid_o low, W edges later. Such an edge creates no result.
- R6: All operand bits at 1 with carry-in 1 gives carry_o = 1 and sum_o with every bit at 1. All operands at 0 gives zero.
- R7: A carry generated at bit 0 ripples through every higher bit in turn. For x all ones, y = 0 and carry-in 1, the result is carry_o = 1 with sum_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the valid flags |
| in_valid_i | input | 1 | Operands on this cycle form an operation |
| x_i | input | W | First operand |
| y_i | input | W | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| valid_o | output | 1 | sum_o and carry_o carry a result |
| sum_o | output | W | Sum bits W-1..0 |
| carry_o | output | 1 | Carry out of bit W-1 |

## Verification
Each operation accepted at a rising edge is due at the output after the W-th following edge. The reference model records every edge, both operations and idle cycles. On each falling edge it compares valid_o and the result against the entry recorded W edges earlier, so a result that comes one cycle early or late fails both the valid check and the value check. The stimulus includes a long burst with no gaps, so that a single lost or duplicated cycle breaks the run-length and count checks. Other phases mix random gaps between operations, so that idle entries have to reach the output as valid_o low.

// File: rtl/rca_pipe_pkg.sv
package rca_pipe_pkg;
  parameter int unsigned RCA_W_DEFAULT = 4;

  // level j keeps: carry, j sum bits, (W-j) bits of each operand
  function automatic int lvl_w(input int w, input int j);
    return 2 * w + 1 - j;
  endfunction

  function automatic int lvl_off(input int w, input int j);
    return j * (2 * w + 1) - (j * (j - 1)) / 2;
  endfunction
endpackage

// File: rtl/rca_half_adder.sv
module rca_half_adder (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i;
  assign c_o = a_i & b_i;
endmodule

// File: rtl/rca_full_adder.sv
module rca_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic s_1, c_1, c_2;

  rca_half_adder u_ha0 (.a_i(a_i), .b_i(b_i), .s_o(s_1), .c_o(c_1));
  rca_half_adder u_ha1 (.a_i(s_1), .b_i(c_i), .s_o(s_o), .c_o(c_2));

  assign c_o = c_1 | c_2;
endmodule

// File: rtl/rca_valid_pipe.sv
module rca_valid_pipe #(
  parameter int unsigned DEPTH = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[DEPTH-2:0], valid_i};
  end

  assign valid_o = vld_q[DEPTH-1];
endmodule

// File: rtl/rca_pipe_adder.sv
module rca_pipe_adder
  import rca_pipe_pkg::*;
#(
  parameter int unsigned W = RCA_W_DEFAULT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         carry_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int WI    = int'(W);
  localparam int LVLS  = WI + 1;
  localparam int TOT   = lvl_off(WI, LVLS);
  localparam int F_OFF = lvl_off(WI, WI);

  // all levels packed back to back; layout per level j:
  // [0] carry, [1 +: j] sums, [1+j +: W-j] x rest, [W+1 +: W-j] y rest
  logic [TOT-1:0] pipe_d, pipe_q;

  assign pipe_d[0 +: lvl_w(WI, 0)] = {y_i, x_i, carry_i};

  for (genvar j = 1; j <= WI; j++) begin : g_lvl
    localparam int P = lvl_off(WI, j - 1);
    localparam int C = lvl_off(WI, j);
    logic s_bit, c_bit;

    rca_full_adder u_fa (
      .a_i(pipe_q[P + j]),
      .b_i(pipe_q[P + WI + 1]),
      .c_i(pipe_q[P]),
      .s_o(s_bit),
      .c_o(c_bit)
    );

    assign pipe_d[C]     = c_bit;
    assign pipe_d[C + j] = s_bit;

    if (j > 1) begin : g_sums
      assign pipe_d[C + 1 +: j - 1] = pipe_q[P + 1 +: j - 1];
    end

    if (j < WI) begin : g_ops
      assign pipe_d[C + 1 + j +: WI - j]  = pipe_q[P + j + 1 +: WI - j];
      assign pipe_d[C + WI + 1 +: WI - j] = pipe_q[P + WI + 2 +: WI - j];
    end
  end

  // data path is not reset; validity is tracked separately
  always_ff @(posedge clk_i) pipe_q <= pipe_d;

  rca_valid_pipe #(.DEPTH(LVLS)) u_vld (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(in_valid_i),
    .valid_o(valid_o)
  );

  assign carry_o = pipe_q[F_OFF];
  assign sum_o   = pipe_q[F_OFF + 1 +: WI];
endmodule

// File: rtl/rca_pipe_adder_chk.sv
module rca_pipe_adder_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic         carry_i,
  input logic         valid_o,
  input logic [W-1:0] sum_o,
  input logic         carry_o
);
  localparam int D = int'(W) + 1;

  logic         sh_v    [D];
  logic [W:0]   sh_r    [D];
  logic         sh_ones [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) begin
        sh_v[i]    <= 1'b0;
        sh_r[i]    <= '0;
        sh_ones[i] <= 1'b0;
      end
    end else begin
      sh_v[0]    <= in_valid_i;
      sh_r[0]    <= {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, carry_i};
      sh_ones[0] <= (&x_i) & (&y_i) & carry_i;
      for (int i = 1; i < D; i++) begin
        sh_v[i]    <= sh_v[i-1];
        sh_r[i]    <= sh_r[i-1];
        sh_ones[i] <= sh_ones[i-1];
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) $rose(rst_ni) |-> !valid_o);

  p_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({carry_o, sum_o} == sh_r[D-1]));

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_v[D-1] |-> valid_o);

  p_back_to_back_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_v[D-1] && sh_v[D-2]) |=> valid_o);

  p_bubble_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sh_v[D-1] |-> !valid_o);

  p_all_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sh_ones[D-1]) |-> (carry_o && (&sum_o)));
endmodule

bind rca_pipe_adder rca_pipe_adder_chk #(.W(W)) u_chk (.*);

// File: tb/rca_pipe_adder_tb.sv
module rca_pipe_adder_tb;
  localparam int W = 4;

  typedef struct {
    bit         v;
    logic [W:0] r;
    int         tag;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [W-1:0] x_i = '0;
  logic [W-1:0] y_i = '0;
  logic         carry_i = 1'b0;
  logic         valid_o;
  logic [W-1:0] sum_o;
  logic         carry_o;

  int   n_chk = 0;
  int   n_err = 0;
  int   run = 0;
  int   max_run = 0;
  int   n_in = 0;
  int   n_out = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  rca_pipe_adder #(.W(W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: record every accepted edge
  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_t e;
      e.v   = in_valid_i;
      e.r   = {1'b0, x_i} + {1'b0, y_i} + (W+1)'(carry_i);
      e.tag = ((&x_i) && (&y_i) && carry_i) || (x_i == 0 && y_i == 0 && !carry_i) ? 6 :
              ((&x_i) && y_i == 0 && carry_i) ? 7 : 2;
      q.push_back(e);
      if (in_valid_i) n_in++;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      check(valid_o == 1'b0, "R1 reset", int'(valid_o), 0);
    end else if (q.size() < W + 1) begin
      check(valid_o == 1'b0, "R1 fill", int'(valid_o), 0);
    end else begin
      exp_t e;
      e = q[q.size() - 1 - W];
      check(valid_o == e.v, e.v ? "R3 latency" : "R5 bubble", int'(valid_o), int'(e.v));
      if (e.v && valid_o) begin
        case (e.tag)
          6:       check({carry_o, sum_o} == e.r, "R6 extreme", int'({carry_o, sum_o}), int'(e.r));
          7:       check({carry_o, sum_o} == e.r, "R7 ripple", int'({carry_o, sum_o}), int'(e.r));
          default: check({carry_o, sum_o} == e.r, "R2 sum", int'({carry_o, sum_o}), int'(e.r));
        endcase
      end
      while (q.size() > W + 1) void'(q.pop_front());
    end
    if (rst_ni && valid_o) begin
      n_out++;
      run++;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  task automatic send(input bit v, input logic [W-1:0] x, input logic [W-1:0] y, input bit c);
    @(negedge clk_i);
    in_valid_i = v;
    x_i        = x;
    y_i        = y;
    carry_i    = c;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // directed corners
    send(1, '1, '1, 1);
    send(1, '0, '0, 0);
    send(1, '1, '0, 1);
    send(0, '1, '1, 1);
    send(1, '0, '1, 1);
    // R4 burst, no gaps
    for (int i = 0; i < 200; i++) send(1, W'($urandom), W'($urandom), 1'($urandom));
    send(0, '0, '0, 0);
    send(0, '0, '0, 0);
    // random gaps
    for (int i = 0; i < 300; i++)
      send(1'($urandom_range(0, 2) != 0), W'($urandom), W'($urandom), 1'($urandom));
    // exhaustive sweep
    for (int i = 0; i < (1 << (2 * W + 1)); i++)
      send(1, W'(i), W'(i >> W), 1'(i >> (2 * W)));
    send(0, '0, '0, 0);
    repeat (W + 4) @(negedge clk_i);
    check(max_run >= 200, "R4 run length", max_run, 200);
    check(n_out == n_in, "R4 count", n_out, n_in);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule